// File: doc/BRIEF.md
# Status Register Write-Protection Unit

This unit owns the status byte of a serial nonvolatile memory and decides, cycle by cycle, whether the memory array and the status byte itself may be written. The command engine in front of it has already decoded the serial frame. It passes in single-cycle strobes: latch set, latch clear, status write with its data byte, and completed memory write. It also passes in a strobe marking the start of each frame, and the byte address the current memory write targets. The active-low write-protect pin is sampled once, at the frame-start strobe, and that level holds for the rest of the frame.

Three mechanisms combine to guard writes. The first is a write-enable latch that clears itself after every successful write. The second is a hardware pin, which is only heeded when the lock-enable bit is set. The third is a two-bit region code that fences off the top quarter, the top half or the whole array. All inputs are plain control strobes with no handshake. The unit never stalls, and every strobe takes effect at the next clock edge.

Top module: `sr_guard`

## Requirements
- R1: After reset the status byte reads 8'h00, and both permit outputs are 0.
- R2: The status byte is laid out as bit 7 lock-enable, bits 3:2 region code, bit 1 write-enable latch, and bits 6:4 and 0 always read 0.
- R3: A latch-set strobe sets the latch at the next edge, and a latch-clear strobe clears it.
- R4: A status write never changes the latch bit or the reserved bits, whatever data byte it carries.
- R5: An accepted status write clears the latch. A completed memory write clears the latch only if its address was permitted. Refused writes leave the latch set.
- R6: The region code gives the blocked byte addresses as follows: 00 blocks none; 01 blocks addresses whose top two bits are 11; 10 blocks addresses whose top bit is 1; 11 blocks all addresses.
- R7: While the latch is 0, both the memory permit and the status permit are 0.
- R8: With the latch set, a status write is refused only when lock-enable is 1 and the sampled pin is low. When lock-enable is 0, the pin has no effect.
- R9: The memory permit depends only on the latch, the region code and the address, and never on the write-protect pin.
- R10: The pin is sampled at the frame-start strobe. A change of the pin later in the frame does not alter the status permit.
- R11: A refused status write leaves every bit of the status byte unchanged.
- R12: When a clearing event and a latch-set strobe arrive in the same cycle, the latch ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Strobe at chip-select falling edge; samples the pin |
| wp_n | input | 1 | Active-low hardware write-protect pin |
| cmd_latch_set | input | 1 | Set write-enable latch |
| cmd_latch_clr | input | 1 | Clear write-enable latch |
| cmd_sr_write | input | 1 | Status write strobe carrying sr_wdata |
| sr_wdata | input | 8 | Data byte of the status write |
| cmd_mem_done | input | 1 | A memory byte write to tgt_addr completed |
| tgt_addr | input | ADDR_W | Byte address of the current memory access |
| sr_rdata | output | 8 | Status byte for reads |
| mem_wr_ok | output | 1 | Memory write to tgt_addr permitted |
| sr_wr_ok | output | 1 | Status write permitted |

## Verification
The bench builds the unit with ADDR_W = 10. This makes a walk over every byte address affordable for each of the four region codes. The walk runs with the latch both set and clear and with the pin at both levels, so every region boundary and the pin's lack of effect on memory permits are covered completely. Status writes are swept over all 256 data bytes for each combination of lock-enable, sampled pin and latch state. Expected values come from an arithmetic model of the region thresholds and the permit rules.

// File: rtl/sg_pkg.sv
package sg_pkg;
  // Bit positions other logic decodes from the status byte
  localparam int unsigned LOCK_BIT  = 7;
  localparam int unsigned REG_HI    = 3;
  localparam int unsigned REG_LO    = 2;
  localparam int unsigned LATCH_BIT = 1;
  localparam int unsigned REG_W     = REG_HI - REG_LO + 1;

  typedef struct packed {
    logic             lock_en;
    logic [REG_W-1:0] region;
    logic             latch;
  } sg_state_t;

  function automatic logic [7:0] sg_pack(input sg_state_t s);
    logic [7:0] b;
    b = 8'h00;
    b[LOCK_BIT]      = s.lock_en;
    b[REG_HI:REG_LO] = s.region;
    b[LATCH_BIT]     = s.latch;
    return b;
  endfunction
endpackage

// File: rtl/sg_pin_sample.sv
module sg_pin_sample (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic wp_n,
  output logic pin_lvl
);
  always_ff @(posedge clk) begin
    if (!rst_n)           pin_lvl <= 1'b1;
    else if (frame_start) pin_lvl <= wp_n;
  end
endmodule

// File: rtl/sg_region_map.sv
module sg_region_map #(
  parameter int unsigned ADDR_W = 14
) (
  input  logic [1:0]        region,
  input  logic [ADDR_W-1:0] addr,
  output logic              blocked
);
  localparam int unsigned TOP = ADDR_W - 1;
  logic [1:0] hi2;

  generate
    if (ADDR_W >= 2) begin : g_wide
      assign hi2 = addr[TOP -: 2];
    end else begin : g_narrow
      assign hi2 = {addr[0], addr[0]};
    end
  endgenerate

  always_comb begin
    unique case (region)
      2'b00:   blocked = 1'b0;
      2'b01:   blocked = &hi2;
      2'b10:   blocked = hi2[1];
      default: blocked = 1'b1;
    endcase
  end
endmodule

// File: rtl/sg_status_reg.sv
module sg_status_reg
  import sg_pkg::*;
#(
  parameter logic       LOCK_RST   = 1'b0,
  parameter logic [1:0] REGION_RST = 2'b00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       latch_set,
  input  logic       latch_clr,
  input  logic       sr_take,
  input  logic       lock_d,
  input  logic [1:0] region_d,
  input  logic       mem_take,
  output sg_state_t  st
);
  logic clear_ev;
  assign clear_ev = latch_clr | sr_take | mem_take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st.lock_en <= LOCK_RST;
      st.region  <= REGION_RST;
      st.latch   <= 1'b0;
    end else begin
      if (sr_take) begin
        st.lock_en <= lock_d;
        st.region  <= region_d;
      end
      if (clear_ev)       st.latch <= 1'b0;
      else if (latch_set) st.latch <= 1'b1;
    end
  end
endmodule

// File: rtl/sr_guard.sv
module sr_guard
  import sg_pkg::*;
#(
  parameter int unsigned ADDR_W     = 14,
  parameter logic        LOCK_RST   = 1'b0,
  parameter logic [1:0]  REGION_RST = 2'b00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              wp_n,
  input  logic              cmd_latch_set,
  input  logic              cmd_latch_clr,
  input  logic              cmd_sr_write,
  input  logic [7:0]        sr_wdata,
  input  logic              cmd_mem_done,
  input  logic [ADDR_W-1:0] tgt_addr,
  output logic [7:0]        sr_rdata,
  output logic              mem_wr_ok,
  output logic              sr_wr_ok
);
  sg_state_t st;
  logic      pin_lvl;
  logic      blocked;

  sg_pin_sample u_pin (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .wp_n(wp_n), .pin_lvl(pin_lvl)
  );

  sg_region_map #(.ADDR_W(ADDR_W)) u_map (
    .region(st.region), .addr(tgt_addr), .blocked(blocked)
  );

  assign sr_wr_ok  = st.latch & ~(st.lock_en & ~pin_lvl);
  assign mem_wr_ok = st.latch & ~blocked;

  sg_status_reg #(.LOCK_RST(LOCK_RST), .REGION_RST(REGION_RST)) u_sr (
    .clk(clk), .rst_n(rst_n),
    .latch_set(cmd_latch_set), .latch_clr(cmd_latch_clr),
    .sr_take(cmd_sr_write & sr_wr_ok),
    .lock_d(sr_wdata[LOCK_BIT]), .region_d(sr_wdata[REG_HI:REG_LO]),
    .mem_take(cmd_mem_done & mem_wr_ok),
    .st(st)
  );

  assign sr_rdata = sg_pack(st);
endmodule

// File: rtl/sg_checker.sv
module sg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_start,
  input logic       wp_n,
  input logic       cmd_latch_set,
  input logic       cmd_latch_clr,
  input logic       cmd_sr_write,
  input logic [7:0] sr_wdata,
  input logic       cmd_mem_done,
  input logic [7:0] sr_rdata,
  input logic       mem_wr_ok,
  input logic       sr_wr_ok,
  input logic       pin_lvl
);
  // R3
  latch_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_latch_set && !cmd_latch_clr && !cmd_sr_write && !cmd_mem_done) |=> sr_rdata[1]);

  // R12
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_latch_clr |=> !sr_rdata[1]);

  // R4
  sr_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_sr_write && sr_wr_ok) |=> (sr_rdata == ($past(sr_wdata) & 8'h8C)));

  // R11
  sr_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_sr_write && !sr_wr_ok && !cmd_latch_set) |=> $stable(sr_rdata));

  // R7
  latch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_rdata[1] |-> (!mem_wr_ok && !sr_wr_ok));

  // R5
  mem_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_mem_done && mem_wr_ok) |=> !sr_rdata[1]);

  // R10
  pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(pin_lvl));

  // R8
  pin_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_rdata[1] && !sr_rdata[7]) |-> sr_wr_ok);

  // R10
  pin_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (pin_lvl == $past(wp_n)));
endmodule

bind sr_guard sg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .wp_n(wp_n),
  .cmd_latch_set(cmd_latch_set), .cmd_latch_clr(cmd_latch_clr),
  .cmd_sr_write(cmd_sr_write), .sr_wdata(sr_wdata), .cmd_mem_done(cmd_mem_done),
  .sr_rdata(sr_rdata), .mem_wr_ok(mem_wr_ok), .sr_wr_ok(sr_wr_ok),
  .pin_lvl(pin_lvl)
);

// File: tb/sim_sr_guard.sv
`timescale 1ns/1ps
module sim_sr_guard;
  localparam int AW = 10;

  logic clk = 0;
  logic rst_n = 0;
  logic frame_start = 0, wp_n = 1;
  logic cmd_latch_set = 0, cmd_latch_clr = 0, cmd_sr_write = 0, cmd_mem_done = 0;
  logic [7:0] sr_wdata = 0;
  logic [AW-1:0] tgt_addr = 0;
  logic [7:0] sr_rdata;
  logic mem_wr_ok, sr_wr_ok;

  int checks = 0, errors = 0;
  bit m_lock = 0, m_latch = 0, m_pin = 1;
  bit [1:0] m_reg = 0;

  always #2.5 clk = ~clk;

  sr_guard #(.ADDR_W(AW)) u0 (.*);

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit exp_blocked(bit [1:0] r, int a);
    case (r)
      2'd0: return 0;
      2'd1: return a >= 3 * (1 << (AW - 2));
      2'd2: return a >= (1 << (AW - 1));
      default: return 1;
    endcase
  endfunction

  function automatic bit exp_sr_ok();
    return m_latch && !(m_lock && !m_pin);
  endfunction

  function automatic logic [7:0] exp_byte();
    return {m_lock, 3'b000, m_reg, m_latch, 1'b0};
  endfunction

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_lock = 0; m_latch = 0; m_pin = 1; m_reg = 0;
  endtask

  task automatic frame(bit pin);
    @(negedge clk);
    frame_start = 1; wp_n = pin;
    @(negedge clk);
    frame_start = 0;
    m_pin = pin;
  endtask

  // one command cycle; model updated from the requirements, status byte checked after
  task automatic op(bit ls, bit lc, bit sw, logic [7:0] wd, bit md, string req);
    bit sok, mok, clr;
    @(negedge clk);
    sok = exp_sr_ok();
    mok = m_latch && !exp_blocked(m_reg, int'(tgt_addr));
    check({req, " sr permit"}, sr_wr_ok, sok);
    cmd_latch_set = ls; cmd_latch_clr = lc; cmd_sr_write = sw;
    sr_wdata = wd; cmd_mem_done = md;
    @(negedge clk);
    cmd_latch_set = 0; cmd_latch_clr = 0; cmd_sr_write = 0; cmd_mem_done = 0;
    clr = lc || (sw && sok) || (md && mok);
    if (sw && sok) begin m_lock = wd[7]; m_reg = wd[3:2]; end
    if (clr) m_latch = 0; else if (ls) m_latch = 1;
    check({req, " status byte R2"}, sr_rdata, exp_byte());
  endtask

  task automatic sweep_addr(string req);
    for (int a = 0; a < (1 << AW); a++) begin
      @(negedge clk);
      tgt_addr = a[AW-1:0];
      #1;
      check(req, mem_wr_ok, m_latch && !exp_blocked(m_reg, a));
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R1
    check("R1 reset byte", sr_rdata, 8'h00);
    check("R1 mem permit", mem_wr_ok, 0);
    check("R1 sr permit", sr_wr_ok, 0);

    // R3
    op(1, 0, 0, 0, 0, "R3 set");
    check("R3 latch set", sr_rdata[1], 1);
    op(0, 1, 0, 0, 0, "R3 clear");
    check("R3 latch clear", sr_rdata[1], 0);

    // R4 R8 R11 R5: all data bytes under every lock/pin/latch combination
    for (int lk = 0; lk < 2; lk++)
      for (int pn = 0; pn < 2; pn++)
        for (int lt = 0; lt < 2; lt++)
          for (int d = 0; d < 256; d++) begin
            do_reset();
            frame(1);
            op(1, 0, 0, 0, 0, "R3");
            op(0, 0, 1, {lk[0], 7'b0000100}, 0, "R8 setup");
            if (lt != 0) op(1, 0, 0, 0, 0, "R3");
            frame(pn[0]);
            op(0, 0, 1, d[7:0], 0, "R4 R5 R8 R11");
          end

    // R6 R7 R9: every address, every region, both pin levels, latch set and clear
    for (int r = 0; r < 4; r++) begin
      do_reset();
      frame(1);
      op(1, 0, 0, 0, 0, "R3");
      op(0, 0, 1, {4'b0000, r[1:0], 2'b11}, 0, "R6 setup");
      op(1, 0, 0, 0, 0, "R3");
      for (int pn = 0; pn < 2; pn++) begin
        frame(pn[0]);
        sweep_addr("R6 R9 region map");
      end
      op(0, 1, 0, 0, 0, "R7");
      sweep_addr("R7 latch low");
      check("R7 sr permit", sr_wr_ok, 0);
    end

    // R5: completed memory writes, refused then accepted
    do_reset();
    frame(1);
    op(1, 0, 0, 0, 0, "R3");
    op(0, 0, 1, 8'h04, 0, "R5 setup");
    op(1, 0, 0, 0, 0, "R3");
    tgt_addr = 10'h3F0;
    op(0, 0, 0, 0, 1, "R5 refused mem");
    check("R5 latch kept", sr_rdata[1], 1);
    tgt_addr = 10'h010;
    op(0, 0, 0, 0, 1, "R5 accepted mem");
    check("R5 latch cleared", sr_rdata[1], 0);

    // R10: pin drop mid-frame is ignored
    do_reset();
    frame(1);
    op(1, 0, 0, 0, 0, "R3");
    op(0, 0, 1, 8'h80, 0, "R10 setup");
    op(1, 0, 0, 0, 0, "R3");
    frame(1);
    @(negedge clk); wp_n = 0;
    @(negedge clk);
    check("R10 held sample", sr_wr_ok, 1);
    op(0, 0, 1, 8'h08, 0, "R10 write");
    check("R10 write taken", sr_rdata, 8'h08);
    frame(0);
    op(1, 0, 0, 0, 0, "R3");
    check("R10 new sample", sr_wr_ok, 1);

    // R12: clearing events beat a same-cycle set
    op(1, 1, 0, 0, 0, "R12 set+clr");
    check("R12 set+clr", sr_rdata[1], 0);
    op(1, 0, 0, 0, 0, "R3");
    op(1, 0, 1, 8'h00, 0, "R12 set+write");
    check("R12 set+write", sr_rdata[1], 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule